// File: doc/BRIEF.md
# Page-Confined Write Burst Splitter

This block turns one write transfer request into a series of incrementing write-address bursts. No burst it emits reaches past a 4 KB (0x1000) address boundary. A request carries a start address, a total byte count and a beat size, and it is accepted on a valid/ready command port. The block then walks through the request chunk by chunk. For each chunk it takes the smallest of three limits: the bytes still owed, the bytes left before the next 0x1000 boundary, and 256 beats. It presents that chunk on a write-address valid/ready handshake, and after the handshake moves on from the chunk's end.

When the last chunk has been accepted, the block raises a one-cycle completion pulse and returns to idle. A request that fits inside one 4 KB page therefore goes out as a single burst. A request that spans pages is cut exactly at each page edge. The write data channel, responses, read channels and partial-beat handling belong to other blocks.

Top module: `burst_4k_splitter`

## Requirements
- R1: While reset is applied and in the first cycle after it, `cmd_ready` is 1, `aw_valid` is 0 and `done` is 0.
- R2: Every presented burst lies wholly inside one 0x1000-aligned region: address bits [31:12] of its first byte and of its last byte (`aw_addr + (aw_len+1)*2^aw_size - 1`) are equal.
- R3: A burst carries chunk bytes equal to the smallest of the remaining request bytes, 0x1000 minus `aw_addr[11:0]`, and 256 beats. `aw_len` is (chunk bytes / 2^aw_size) - 1. Example: 16 bytes at 0xFF8 with size 2 gives two bursts, 0xFF8 with len 1 and then 0x1000 with len 1.
- R4: The first burst starts at the request address. Each later burst starts at the byte after the previous burst's last byte, and the burst byte counts add up to the request byte count.
- R5: A request whose byte range stays within one 0x1000 region goes out as exactly one burst.
- R6: Every burst has `aw_burst` = 2'b01 (incrementing), and `aw_size` equals the request's `cmd_size`.
- R7: While `aw_valid` is 1 and `aw_ready` is 0, `aw_valid` stays 1 in the next cycle, and `aw_addr`, `aw_len` and `aw_size` keep their values.
- R8: `done` is 1 for exactly one cycle, namely the cycle after the final burst's handshake. `cmd_ready` is 0 from the cycle after a command is accepted until that `done` cycle, and it returns to 1 in the cycle after `done`.
- R9: When the 256-beat limit is the smallest of the three, the chunk is 256 beats (`aw_len` = 255). Example: 1024 bytes at 0x0 with size 0 gives four bursts of len 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request is presented |
| cmd_ready | output | 1 | Block is idle and accepts a request |
| cmd_addr | input | ADDR_W | Byte start address, a multiple of 2^cmd_size |
| cmd_bytes | input | CNT_W | Total bytes, nonzero and a multiple of 2^cmd_size |
| cmd_size | input | SIZE_W | Beat size as log2 of bytes per beat |
| aw_valid | output | 1 | Burst is presented |
| aw_ready | input | 1 | Downstream accepts the burst |
| aw_addr | output | ADDR_W | Burst start address |
| aw_len | output | LEN_W | Beats in the burst minus one |
| aw_size | output | SIZE_W | Beat size of the burst |
| aw_burst | output | 2 | Burst type, always incrementing (2'b01) |
| done | output | 1 | One-cycle pulse once the last burst is accepted |

## Verification
The embedded properties assume a well-formed request: a nonzero byte count, an address and a count that are both whole multiples of the beat size, and a range that does not wrap past the top of the address space. `cmd_valid` is only meaningful while `cmd_ready` is high. The stimulus respects these assumptions by construction. It masks every random address down to a beat multiple and draws the byte count as a nonzero number of beats. It keeps addresses far below the address-space top. It also pulls `aw_ready` low at random, so that the hold property and the contiguity check see both stalled and back-to-back handshakes.

// File: rtl/axsplit_pkg.sv
package axsplit_pkg;

    typedef enum logic [1:0] {
        SPL_IDLE  = 2'd0,
        SPL_ISSUE = 2'd1,
        SPL_FIN   = 2'd2
    } spl_state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;

    // smallest of three unsigned byte counts
    function automatic logic [31:0] min3(input logic [31:0] a,
                                         input logic [31:0] b,
                                         input logic [31:0] c);
        logic [31:0] m;
        m = (a < b) ? a : b;
        return (m < c) ? m : c;
    endfunction

endpackage

// File: rtl/axs_chunk_calc.sv
module axs_chunk_calc
    import axsplit_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned SIZE_W     = 3,
    parameter int unsigned BOUND_BITS = 12,
    parameter int unsigned MAX_BEATS  = 256,
    localparam int unsigned LEN_W     = $clog2(MAX_BEATS)
) (
    input  logic [BOUND_BITS-1:0] addr_low,
    input  logic [CNT_W-1:0]      remaining,
    input  logic [SIZE_W-1:0]     size,
    output logic [CNT_W-1:0]      chunk_bytes,
    output logic [LEN_W-1:0]      beats_m1,
    output logic                  is_last
);
    localparam logic [31:0] REGION_BYTES = 32'(1) << BOUND_BITS;

    logic [31:0] rem32;
    logic [31:0] to_edge;
    logic [31:0] beat_cap;
    logic [31:0] chunk32;
    logic [31:0] beats32;

    always_comb begin
        rem32    = 32'(remaining);
        to_edge  = REGION_BYTES - 32'(addr_low);
        beat_cap = 32'(MAX_BEATS) << size;
        chunk32  = min3(rem32, to_edge, beat_cap);
        beats32  = chunk32 >> size;
    end

    assign chunk_bytes = CNT_W'(chunk32);
    assign beats_m1    = LEN_W'(beats32 - 32'd1);
    assign is_last     = (chunk32 == rem32);

endmodule

// File: rtl/axs_seq_fsm.sv
module axs_seq_fsm
    import axsplit_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_bytes,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic              aw_ready,
    input  logic [CNT_W-1:0]  chunk_bytes,
    input  logic              is_last,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  remaining,
    output logic [SIZE_W-1:0] cur_size,
    output logic              in_idle,
    output logic              in_issue,
    output logic              in_fin
);
    spl_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SPL_IDLE;
            cur_addr  <= '0;
            remaining <= '0;
            cur_size  <= '0;
        end else begin
            unique case (state_q)
                SPL_IDLE: begin
                    if (cmd_valid) begin
                        cur_addr  <= cmd_addr;
                        remaining <= cmd_bytes;
                        cur_size  <= cmd_size;
                        state_q   <= SPL_ISSUE;
                    end
                end
                SPL_ISSUE: begin
                    if (aw_ready) begin
                        cur_addr  <= cur_addr + ADDR_W'(chunk_bytes);
                        remaining <= remaining - chunk_bytes;
                        if (is_last) state_q <= SPL_FIN;
                    end
                end
                SPL_FIN:  state_q <= SPL_IDLE;
                default:  state_q <= SPL_IDLE;
            endcase
        end
    end

    assign in_idle  = (state_q == SPL_IDLE);
    assign in_issue = (state_q == SPL_ISSUE);
    assign in_fin   = (state_q == SPL_FIN);

endmodule

// File: rtl/burst_4k_splitter.sv
module burst_4k_splitter
    import axsplit_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned SIZE_W     = 3,
    parameter int unsigned BOUND_BITS = 12,
    parameter int unsigned MAX_BEATS  = 256,
    localparam int unsigned LEN_W     = $clog2(MAX_BEATS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_bytes,
    input  logic [SIZE_W-1:0] cmd_size,
    output logic              aw_valid,
    input  logic              aw_ready,
    output logic [ADDR_W-1:0] aw_addr,
    output logic [LEN_W-1:0]  aw_len,
    output logic [SIZE_W-1:0] aw_size,
    output logic [1:0]        aw_burst,
    output logic              done
);
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remaining;
    logic [SIZE_W-1:0] cur_size;
    logic [CNT_W-1:0]  chunk_bytes;
    logic [LEN_W-1:0]  beats_m1;
    logic              is_last;
    logic              in_idle, in_issue, in_fin;

    axs_seq_fsm #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .SIZE_W (SIZE_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_addr    (cmd_addr),
        .cmd_bytes   (cmd_bytes),
        .cmd_size    (cmd_size),
        .aw_ready    (aw_ready),
        .chunk_bytes (chunk_bytes),
        .is_last     (is_last),
        .cur_addr    (cur_addr),
        .remaining   (remaining),
        .cur_size    (cur_size),
        .in_idle     (in_idle),
        .in_issue    (in_issue),
        .in_fin      (in_fin)
    );

    axs_chunk_calc #(
        .CNT_W      (CNT_W),
        .SIZE_W     (SIZE_W),
        .BOUND_BITS (BOUND_BITS),
        .MAX_BEATS  (MAX_BEATS)
    ) u_calc (
        .addr_low    (cur_addr[BOUND_BITS-1:0]),
        .remaining   (remaining),
        .size        (cur_size),
        .chunk_bytes (chunk_bytes),
        .beats_m1    (beats_m1),
        .is_last     (is_last)
    );

    assign cmd_ready = in_idle;
    assign aw_valid  = in_issue;
    assign aw_addr   = cur_addr;
    assign aw_len    = beats_m1;
    assign aw_size   = cur_size;
    assign aw_burst  = BURST_INCR;
    assign done      = in_fin;

    // last byte of the presented burst, rebuilt from the output fields
    logic [ADDR_W:0] span_last;
    assign span_last = {1'b0, aw_addr}
                     + ((((ADDR_W+1)'(aw_len)) + (ADDR_W+1)'(1)) << aw_size)
                     - (ADDR_W+1)'(1);

    assert_no_cross_R2: assert property (@(posedge clk) disable iff (rst)
        aw_valid |-> (span_last[ADDR_W-1:BOUND_BITS] == aw_addr[ADDR_W-1:BOUND_BITS]));

    assert_contig_R4: assert property (@(posedge clk) disable iff (rst)
        (aw_valid && aw_ready) |=> (!aw_valid ||
            aw_addr == $past(aw_addr)
                     + ((ADDR_W'($past(aw_len)) + ADDR_W'(1)) << $past(aw_size))));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (aw_valid && !aw_ready) |=> (aw_valid && $stable(aw_addr)
                                     && $stable(aw_len) && $stable(aw_size)));

    assert_done_after_hs_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(aw_valid && aw_ready));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && cmd_ready));

endmodule

// File: tb/tb_burst_4k_splitter.sv
module tb_burst_4k_splitter;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [31:0] cmd_addr;
    logic [15:0] cmd_bytes;
    logic [2:0]  cmd_size;
    logic        aw_valid;
    logic        aw_ready;
    logic [31:0] aw_addr;
    logic [7:0]  aw_len;
    logic [2:0]  aw_size;
    logic [1:0]  aw_burst;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit wd_hit = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_4k_splitter dut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .cmd_size(cmd_size),
        .aw_valid(aw_valid), .aw_ready(aw_ready),
        .aw_addr(aw_addr), .aw_len(aw_len), .aw_size(aw_size),
        .aw_burst(aw_burst), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int unsigned exp_chunk(input int unsigned cur,
                                              input int unsigned rem,
                                              input int unsigned sz);
        int unsigned m;
        m = rem;
        if (4096 - (cur % 4096) < m) m = 4096 - (cur % 4096);
        if ((256 << sz) < m) m = 256 << sz;
        return m;
    endfunction

    function automatic int exp_count(input int unsigned a, input int unsigned n,
                                     input int unsigned sz);
        int c = 0;
        while (n > 0) begin
            int unsigned ch;
            ch = exp_chunk(a, n, sz);
            a += ch; n -= ch; c++;
        end
        return c;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !wd_hit) begin
            wd_hit = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_req(input int unsigned a, input int unsigned n,
                           input int unsigned sz, input bit stall);
        int unsigned cur, rem, ch;
        int nb, expn;
        bit rdy;
        expn = exp_count(a, n, sz);
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R8", "idle cmd_ready", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_addr = a; cmd_bytes = 16'(n); cmd_size = 3'(sz);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R8", "busy cmd_ready", cmd_ready, 0);
        cur = a; rem = n; nb = 0;
        while (rem > 0 && !wd_hit) begin
            ch = exp_chunk(cur, rem, sz);
            chk(aw_valid == 1'b1, "R7", "aw_valid held", aw_valid, 1);
            chk(aw_addr == cur, "R4", "aw_addr", aw_addr, cur);
            chk(aw_len == 8'((ch >> sz) - 1), "R3", "aw_len", aw_len, (ch >> sz) - 1);
            chk(aw_size == 3'(sz) && aw_burst == 2'b01, "R6", "size/burst",
                {aw_size, aw_burst}, {3'(sz), 2'b01});
            chk((cur / 4096) == ((cur + ch - 1) / 4096), "R2", "region",
                (cur + ch - 1) / 4096, cur / 4096);
            chk(done == 1'b0 && cmd_ready == 1'b0, "R8", "no early done",
                {done, cmd_ready}, 0);
            rdy = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
            aw_ready = rdy;
            @(negedge clk);
            if (rdy) begin
                cur += ch; rem -= ch; nb++;
            end
        end
        aw_ready = 1'b0;
        chk(done == 1'b1 && aw_valid == 1'b0 && cmd_ready == 1'b0, "R8", "done pulse",
            {done, aw_valid, cmd_ready}, 3'b100);
        @(negedge clk);
        chk(done == 1'b0 && cmd_ready == 1'b1, "R8", "after done",
            {done, cmd_ready}, 2'b01);
        chk(nb == expn, (expn == 1) ? "R5" : "R3", "burst count", nb, expn);
    endtask

    initial begin
        void'($urandom(32'd20240601));
        rst = 1'b1; cmd_valid = 1'b0; cmd_addr = '0; cmd_bytes = '0; cmd_size = '0;
        aw_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(cmd_ready == 1'b1 && aw_valid == 1'b0 && done == 1'b0, "R1", "in reset",
            {cmd_ready, aw_valid, done}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready == 1'b1 && aw_valid == 1'b0 && done == 1'b0, "R1", "after reset",
            {cmd_ready, aw_valid, done}, 3'b100);

        run_req(32'hFF8, 16, 2, 1'b0);      // R3 example: FF8 len1, 1000 len1
        run_req(32'h100, 64, 3, 1'b1);      // R5 single burst
        run_req(32'h0, 4096, 4, 1'b1);      // R5 full page, len 255
        run_req(32'hF00, 256, 2, 1'b0);     // R5 ends exactly at edge
        run_req(32'h0, 1024, 0, 1'b1);      // R9 four bursts of 256 beats
        run_req(32'h3FC0, 8320, 5, 1'b1);   // R3 multiple page edges
        run_req(32'h7FFE, 4, 0, 1'b0);      // R3 two bytes then two bytes

        for (int i = 0; i < 60; i++) begin
            int unsigned sz, a, beats;
            sz    = $urandom_range(0, 5);
            a     = ($urandom_range(0, 32'h000F_FFFF) >> sz) << sz;
            beats = $urandom_range(1, 600);
            run_req(a, beats << sz, sz, 1'b1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule